// File: doc/BRIEF.md
# Disk Head Step Position Tracker

This block stands in for the positioning half of an old stepper-driven hard disk. A host controller selects the drive, sets a direction level and sends step pulses. The block counts every pulse into a cylinder register and tracks which of the two heads is chosen. It drives the track-zero, seek-complete and ready status lines back to the host. The current cylinder and head are exposed, together with a one-cycle change strobe, so that a neighbouring track buffer knows when to refill.

All host inputs pass through a two-flop synchronizer. A step counts on the synchronized rising edge, and the direction level is taken in that same cycle. After each counted step, seek-complete stays low for a settle window that is set in clock cycles.

The block also models idle auto-parking. If the drive stays unselected for a set number of cycles, the head jumps to a park cylinder and the working cylinder is stored. When the drive is selected again, the head walks back one cylinder per settle window. Seek-complete is withheld until the head reaches the stored cylinder.

Top module: `disk_head_tracker`

## Requirements
- R1: While `drv_sel` is high and the head is not parking or returning, a step rising edge with `dir_in`=1 raises `cyl` by one.
- R2: A step with `dir_in`=0 lowers `cyl` by one. At cylinder 0 the step leaves `cyl` at 0 and `trk0` stays high.
- R3: An inward step at the last cylinder (`CYL_COUNT`-1, default 614) is ignored. `cyl` never exceeds that value.
- R4: While selected, `trk0` is high exactly when `cyl` is 0.
- R5: While `drv_sel` (synchronized) is low, `ready`, `trk0` and `seek_done` are all low. While it is high, `ready` is high.
- R6: After a single counted step, `seek_done` is low for exactly `SETTLE_CYC` cycles and then returns high.
- R7: Step pulses in a burst are each counted. A step that arrives in the same cycle in which the previous settle window would end keeps `seek_done` low without a gap.
- R8: After `IDLE_CYC` consecutive unselected cycles, `cyl` shows `PARK_CYL` (default 614) and the earlier cylinder is stored.
- R9: On reselection after parking, `cyl` moves one cylinder toward the stored value per `SETTLE_CYC` cycles. `seek_done` stays low until `cyl` equals the stored cylinder, and only then goes high.
- R10: Step edges that arrive while the head is returning from park are ignored.
- R11: While selected, `head` follows `head_sel`. `trk_chg` is high for exactly one cycle after each change of `cyl` or `head`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_sel | input | 1 | Drive select from host, active high |
| step | input | 1 | Step pulse from host, counted on rising edge |
| dir_in | input | 1 | Step direction: 1 toward higher cylinders, 0 outward |
| head_sel | input | 1 | Head choice: 0 or 1 |
| cyl | output | 10 | Current cylinder number |
| head | output | 1 | Current head |
| trk0 | output | 1 | Head is at cylinder 0 (gated by select) |
| seek_done | output | 1 | Head settled on its cylinder (gated by select) |
| ready | output | 1 | Drive is selected and ready |
| trk_chg | output | 1 | One-cycle strobe after a cylinder or head change |

## Verification
Two functions can fall in the same cycle: the expiry of one settle window and the edge of the next step in a burst. The bench paces steps at exactly `SETTLE_CYC` cycles from edge to edge, so each new edge lands on the cycle in which the old window would end. The bench then watches `seek_done` over the whole burst and requires it to stay low, and it requires the final cylinder to match a reference count. A second overlap is a step edge during the return from park. The bench injects one and requires that the arrival cylinder and the seek-complete timing are unchanged.

// File: rtl/hdt_pkg.sv
package hdt_pkg;

    typedef enum logic [1:0] {
        HP_ACTIVE = 2'd0,
        HP_PARKED = 2'd1,
        HP_RETURN = 2'd2
    } hd_mode_e;

    typedef struct packed {
        logic sel;
        logic stp;
        logic dir;
        logic hd;
    } host_in_t;

    // Next cylinder for one host step, clamped at both ends of the stroke.
    function automatic int unsigned step_target(int unsigned cur, logic inward,
                                                int unsigned last);
        if (inward)
            return (cur >= last) ? cur : cur + 1;
        else
            return (cur == 0) ? 0 : cur - 1;
    endfunction

    // One cylinder toward a target position.
    function automatic int unsigned walk_toward(int unsigned cur, int unsigned dst);
        if (cur < dst)      return cur + 1;
        else if (cur > dst) return cur - 1;
        else                return cur;
    endfunction

endpackage

// File: rtl/hdt_sync.sv
module hdt_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= '0;
                else if (i == 0)
                    chain[i] <= d;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i - 1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hdt_timer.sv
module hdt_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign last = (cnt == W'(1));
endmodule

// File: rtl/disk_head_tracker.sv
module disk_head_tracker
    import hdt_pkg::*;
#(
    parameter int unsigned CYL_COUNT  = 615,
    parameter int unsigned PARK_CYL   = CYL_COUNT - 1,
    parameter int unsigned SETTLE_CYC = 400,
    parameter int unsigned IDLE_CYC   = 1_000_000_000,
    localparam int unsigned CW = $clog2(CYL_COUNT),
    localparam int unsigned SW = $clog2(SETTLE_CYC + 1),
    localparam int unsigned IW = $clog2(IDLE_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          drv_sel,
    input  logic          step,
    input  logic          dir_in,
    input  logic          head_sel,
    output logic [CW-1:0] cyl,
    output logic          head,
    output logic          trk0,
    output logic          seek_done,
    output logic          ready,
    output logic          trk_chg
);
    localparam int unsigned LAST_CYL = CYL_COUNT - 1;

    host_in_t raw_in, syn_in;
    logic     stp_d;
    logic     step_edge, count_ok;
    logic     settle_busy, settle_last, settle_load, ret_load;

    hd_mode_e      mode;
    logic [CW-1:0] cyl_q, saved_q, cyl_d;
    logic          head_q, head_d;
    logic [IW-1:0] idle_q;

    assign raw_in = '{sel: drv_sel, stp: step, dir: dir_in, hd: head_sel};

    hdt_sync #(.W($bits(host_in_t)), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    always_ff @(posedge clk) begin
        if (rst) stp_d <= 1'b0;
        else     stp_d <= syn_in.stp;
    end

    assign step_edge = syn_in.stp & ~stp_d;
    assign count_ok  = step_edge & syn_in.sel & (mode == HP_ACTIVE);

    // Return walk: leave park on reselection, then move once per window.
    assign ret_load = ((mode == HP_PARKED) && syn_in.sel) ||
                      ((mode == HP_RETURN) && settle_last && (cyl_q != saved_q));
    assign settle_load = count_ok | ret_load;

    hdt_timer #(.W(SW)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .load     (settle_load),
        .load_val (SW'(SETTLE_CYC)),
        .busy     (settle_busy),
        .last     (settle_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= HP_ACTIVE;
            cyl_q   <= '0;
            saved_q <= '0;
            idle_q  <= '0;
        end else begin
            case (mode)
                HP_ACTIVE: begin
                    if (syn_in.sel) begin
                        idle_q <= '0;
                        if (count_ok)
                            cyl_q <= CW'(step_target(int'(cyl_q), syn_in.dir, LAST_CYL));
                    end else if (idle_q == IW'(IDLE_CYC - 1)) begin
                        idle_q  <= '0;
                        saved_q <= cyl_q;
                        cyl_q   <= CW'(PARK_CYL);
                        mode    <= HP_PARKED;
                    end else begin
                        idle_q <= idle_q + 1'b1;
                    end
                end
                HP_PARKED: begin
                    if (syn_in.sel)
                        mode <= HP_RETURN;
                end
                HP_RETURN: begin
                    if (settle_last) begin
                        if (cyl_q == saved_q)
                            mode <= HP_ACTIVE;
                        else
                            cyl_q <= CW'(walk_toward(int'(cyl_q), int'(saved_q)));
                    end
                end
                default: mode <= HP_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= 1'b0;
            head_d <= 1'b0;
            cyl_d  <= '0;
        end else begin
            if (syn_in.sel)
                head_q <= syn_in.hd;
            head_d <= head_q;
            cyl_d  <= cyl_q;
        end
    end

    assign cyl       = cyl_q;
    assign head      = head_q;
    assign trk_chg   = (cyl_q != cyl_d) || (head_q != head_d);
    assign ready     = syn_in.sel;
    assign trk0      = syn_in.sel && (cyl_q == '0);
    assign seek_done = syn_in.sel && (mode == HP_ACTIVE) && !settle_busy;
endmodule

// File: rtl/disk_head_tracker_chk.sv
module disk_head_tracker_chk #(
    parameter int unsigned CYL_COUNT = 615,
    parameter int unsigned CW        = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          ready,
    input logic          trk0,
    input logic          seek_done,
    input logic [CW-1:0] cyl
);
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (!trk0 && !seek_done)); // R5

    AST_CYL_BOUND: assert property (@(posedge clk) disable iff (rst)
        cyl <= CW'(CYL_COUNT - 1)); // R3

    AST_LEAVE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(ready) && $past(cyl) == '0 && cyl != '0) |-> (cyl == CW'(1))); // R2

    AST_SETTLED_STILL: assert property (@(posedge clk) disable iff (rst)
        $rose(seek_done) |-> $stable(cyl)); // R6

    AST_DONE_HOLDS_CYL: assert property (@(posedge clk) disable iff (rst)
        (seek_done && $past(seek_done)) |-> $stable(cyl)); // R9
endmodule

bind disk_head_tracker disk_head_tracker_chk #(.CYL_COUNT(CYL_COUNT), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .trk0      (trk0),
    .seek_done (seek_done),
    .cyl       (cyl)
);

// File: tb/sim_disk_head_tracker.sv
module sim_disk_head_tracker;
    localparam int unsigned NCYL   = 615;
    localparam int unsigned LASTC  = NCYL - 1;
    localparam int unsigned PARKC  = NCYL - 1;
    localparam int unsigned SETTLE = 6;
    localparam int unsigned IDLE   = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       drv_sel = 1'b0, step = 1'b0, dir_in = 1'b0, head_sel = 1'b0;
    logic [9:0] cyl;
    logic       head, trk0, seek_done, ready, trk_chg;

    int tests = 0, fails = 0;
    int exp_cyl = 0;
    int unsigned cycles = 0;
    int unsigned chg_total = 0;
    int unsigned chg_runs = 0;
    logic chg_prev = 1'b0;

    always #2 clk = ~clk;

    disk_head_tracker #(.CYL_COUNT(NCYL), .SETTLE_CYC(SETTLE), .IDLE_CYC(IDLE)) u0 (
        .clk(clk), .rst(rst), .drv_sel(drv_sel), .step(step), .dir_in(dir_in),
        .head_sel(head_sel), .cyl(cyl), .head(head), .trk0(trk0),
        .seek_done(seek_done), .ready(ready), .trk_chg(trk_chg)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (trk_chg) chg_total <= chg_total + 1;
        if (trk_chg && !chg_prev) chg_runs <= chg_runs + 1;
        chg_prev <= trk_chg;
    end

    function automatic int model_step(int cur, logic inward);
        if (inward) return (cur >= int'(LASTC)) ? cur : cur + 1;
        return (cur == 0) ? 0 : cur - 1;
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Edge-to-edge spacing of exactly SETTLE cycles.
    task automatic pulse(logic inward);
        dir_in = inward;
        step   = 1'b1;
        idle(3);
        step   = 1'b0;
        idle(SETTLE - 3);
        exp_cyl = model_step(exp_cyl, inward);
    endtask

    task automatic burst(int n, logic inward, output int done_hits);
        done_hits = 0;
        for (int i = 0; i < n; i++) begin
            dir_in = inward;
            step   = 1'b1;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (i > 0 && seek_done) done_hits++;
            end
            step = 1'b0;
            for (int k = 0; k < int'(SETTLE) - 3; k++) begin
                @(negedge clk);
                if (i > 0 && seek_done) done_hits++;
            end
            exp_cyl = model_step(exp_cyl, inward);
        end
        idle(SETTLE + 4);
    endtask

    task automatic park_and_return(string tag);
        int saved, moves, waited, lo, hi;
        saved = exp_cyl;
        drv_sel = 1'b0;
        idle(IDLE + 10);
        check({tag, " R8 park cylinder"}, int'(cyl), int'(PARKC));
        check({tag, " R5 ready low"}, int'(ready), 0);
        drv_sel = 1'b1;
        waited = 0;
        while (!seek_done && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (waited == 40) begin
                dir_in = 1'b1; step = 1'b1;   // R10 step during return
            end
            if (waited == 43) step = 1'b0;
        end
        moves = (saved > int'(PARKC)) ? saved - int'(PARKC) : int'(PARKC) - saved;
        lo = moves * int'(SETTLE);
        hi = moves * int'(SETTLE) + int'(SETTLE) + 6;
        check({tag, " R9 arrival cylinder"}, int'(cyl), saved);
        check({tag, " R9 return time in window"}, int'(waited >= lo && waited <= hi), 1);
        check({tag, " R10 step during return ignored"}, int'(cyl), saved);
        check({tag, " R4 trk0 after return"}, int'(trk0), int'(saved == 0));
    endtask

    initial begin : watchdog
        wait (cycles > 190000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int hits, lowc, c0, r0;
        void'($urandom(32'd4242));
        idle(4);
        rst = 1'b0;
        idle(3);
        check("R5 reset ready", int'(ready), 0);
        check("R5 reset trk0", int'(trk0), 0);
        check("R5 reset seek_done", int'(seek_done), 0);
        check("reset cyl", int'(cyl), 0);

        drv_sel = 1'b1;
        idle(4);
        check("R5 ready when selected", int'(ready), 1);
        check("R4 trk0 at zero", int'(trk0), 1);
        check("R6 seek_done at rest", int'(seek_done), 1);

        // R2: outward at zero clamps
        pulse(1'b0);
        idle(SETTLE + 4);
        check("R2 clamp at zero", int'(cyl), 0);
        check("R2 trk0 kept", int'(trk0), 1);

        // R6: width of seek_done low after single step
        dir_in = 1'b1; step = 1'b1;
        lowc = 0;
        for (int k = 0; k < int'(SETTLE) + 12; k++) begin
            @(negedge clk);
            if (k == 2) step = 1'b0;
            if (!seek_done) lowc++;
        end
        exp_cyl = 1;
        check("R1 single inward step", int'(cyl), 1);
        check("R6 settle low width", lowc, int'(SETTLE));
        check("R4 trk0 off cylinder", int'(trk0), 0);

        // R11: trk_chg per change
        c0 = int'(chg_total); r0 = int'(chg_runs);
        burst(5, 1'b1, hits);
        check("R11 strobe cycles per step", int'(chg_total) - c0, 5);
        check("R11 strobe pulses per step", int'(chg_runs) - r0, 5);
        check("R7 no gap during paced burst", hits, 0);
        check("R1 burst count", int'(cyl), exp_cyl);
        c0 = int'(chg_total);
        head_sel = 1'b1;
        idle(5);
        check("R11 head follows", int'(head), 1);
        check("R11 strobe on head change", int'(chg_total) - c0, 1);

        // Random walks, mixed direction and burst length
        for (int t = 0; t < 25; t++) begin
            logic d;
            int n;
            d = 1'($urandom_range(0, 1));
            n = int'($urandom_range(1, 30));
            burst(n, d, hits);
            check("R7 random burst cylinder", int'(cyl), exp_cyl);
            check("R7 random burst no gap", hits, 0);
            check("R4 random trk0", int'(trk0), int'(exp_cyl == 0));
            check("R6 settled after burst", int'(seek_done), 1);
        end

        // R3: drive to the last cylinder and beyond
        burst(int'(LASTC) - exp_cyl + 5, 1'b1, hits);
        check("R3 clamp at last cylinder", int'(cyl), int'(LASTC));
        check("R7 long burst no gap", hits, 0);

        // R8/R9/R10: park and return from a middle cylinder, then from zero
        burst(int'(LASTC) - 37, 1'b0, hits);
        check("R2 walk down", int'(cyl), 37);
        park_and_return("mid");
        burst(45, 1'b0, hits);
        check("R2 back to zero", int'(cyl), 0);
        park_and_return("zero");

        // R5: deselect briefly, no park
        drv_sel = 1'b0;
        idle(10);
        check("R5 trk0 gated", int'(trk0), 0);
        check("R5 seek_done gated", int'(seek_done), 0);
        check("R8 short idle keeps cylinder", int'(cyl), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule